// File: doc/BRIEF.md
# Host Bus Slave with Wait and Ready Handshake

This block sits between an asynchronous-strobe CPU bus and an internal target whose response time varies, such as a register file or a memory controller. The host drives chip selects, a read strobe, per-byte write strobes, address and data with no clock. The block brings the strobes into its own clock domain and issues one request per strobe on an internal request/acknowledge port. It returns completion to the host on two pins: an active-low wait line and an active-high ready line. A system wires up whichever of the two its CPU expects.

There are two chip selects: one for register space and one for memory space. A width-select input picks 32-bit or 16-bit host operation. In 16-bit mode the highest write-strobe pin becomes address bit 1. The block then steers the 16-bit host lanes onto the upper or lower half of the 32-bit internal word. The wait and ready pins, and each half of the data bus, come with an output-enable signal so that a pad ring can build the three-state drivers.

Top module: `hbus_slave`

## Requirements
- R1: With `bus32_i` high, a write carries byte enable bit k = NOT `wr_n_i[k]`, the 32 host data bits unchanged, and a read asks for all four byte enables (4'b1111).
- R2: With `bus32_i` low, `wr_n_i[3]` is read as address bit 1 (level, 1 = upper half) and `wr_n_i[2]` is ignored. A write sets byte enables {~wr_n_i[1:0],2'b00} when A1=1 and {2'b00,~wr_n_i[1:0]} when A1=0, and repeats the host's low 16 data bits in both halves. A read asks for 4'b1100 (A1=1) or 4'b0011 (A1=0).
- R3: A register-space request carries word address bits [23:8] as zero and [7:2] from the host. A memory-space request carries all of `addr_i[23:2]`. When both chip selects are active, register space wins.
- R4: The low data half is enabled only while the read strobe and a chip select are both active. The high half is enabled only under the same condition and also in 32-bit mode. In 16-bit mode the low half shows the word half selected by A1.
- R5: With no chip select active, the wait and ready enables are low (high impedance). With a chip select active and no strobe, both enables are high and both pins drive 1.
- R6: From the start of a strobe until the acknowledge is taken, `wait_n_o` is 0 and `ready_o` is 0. After that, both are 1 until the strobe ends.
- R7: Exactly one request is issued per strobe assertion. `req_o` stays high until `ack_i` is sampled, and no further request starts until the strobe has been seen deasserted.
- R8: Read data is captured on the acknowledge and stays on `data_o` without change until the read strobe is released.
- R9: The strobes and chip selects pass through two synchronising flops. `req_o` does not rise in the two clock edges after a strobe becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus32_i | input | 1 | Host width: 1 = 32-bit, 0 = 16-bit |
| cs_reg_n_i | input | 1 | Register-space chip select, active low |
| cs_mem_n_i | input | 1 | Memory-space chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 4 | Byte write strobes, active low; bit 3 is A1 in 16-bit mode |
| addr_i | input | 22 | Host address bits 23..2 |
| data_i | input | 32 | Host write data |
| data_o | output | 32 | Read data toward the host |
| data_oe_o | output | 2 | Output enable for data halves [15:0] and [31:16] |
| wait_n_o | output | 1 | Wait, active low |
| wait_oe_o | output | 1 | Wait pin output enable |
| ready_o | output | 1 | Ready, active high |
| ready_oe_o | output | 1 | Ready pin output enable |
| req_o | output | 1 | Internal request |
| req_we_o | output | 1 | Request is a write |
| req_mem_o | output | 1 | Request targets memory space (0 = register space) |
| req_addr_o | output | 22 | Internal word address |
| req_be_o | output | 4 | Internal byte enables |
| req_wdata_o | output | 32 | Internal write data |
| ack_i | input | 1 | Internal acknowledge, one cycle |
| ack_rdata_i | input | 32 | Internal read data, valid with ack |

## Verification
The assertions check the internal handshake on every cycle. A request is held until it is acknowledged and drops only after an acknowledge. A register-space request never carries upper address bits. A 16-bit request never enables both word halves. Captured read data stays stable while the access is complete. The bench's scenarios are what show the pin-level behaviour: the two-edge synchroniser delay, the wait and ready sequence across different target latencies, half steering through the A1 pin, chip-select priority, the ignored strobe pin, and that a long strobe yields only one request.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int unsigned HB_ADDR_W = 24;
  localparam int unsigned HB_DATA_W = 32;
  localparam int unsigned HB_REG_AW = 8;
  localparam int unsigned HB_NBYTES = HB_DATA_W / 8;
  localparam int unsigned HB_WADDR_W = HB_ADDR_W - 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_DONE = 2'd2
  } seq_state_t;
endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbus_lane_map.sv
module hbus_lane_map #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                bus32_i,
  input  logic [DATA_W/8-1:0] wr_n_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                bus32_q_i,
  input  logic                a1_q_i,
  input  logic [DATA_W-1:0]   rdata_q_i,
  output logic                wr_act_o,
  output logic                a1_o,
  output logic [DATA_W/8-1:0] wr_be_o,
  output logic [DATA_W/8-1:0] rd_be_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [DATA_W-1:0]   pin_rdata_o
);
  localparam int unsigned NB   = DATA_W / 8;
  localparam int unsigned HNB  = NB / 2;
  localparam int unsigned HALF = DATA_W / 2;

  logic [HNB-1:0] lo_strb;

  assign lo_strb = ~wr_n_i[HNB-1:0];
  assign a1_o    = wr_n_i[NB-1];

  always_comb begin
    if (bus32_i) begin
      wr_act_o = |(~wr_n_i);
      wr_be_o  = ~wr_n_i;
      rd_be_o  = '1;
      wdata_o  = data_i;
    end else begin
      wr_act_o = |lo_strb;
      wr_be_o  = a1_o ? {lo_strb, {HNB{1'b0}}} : {{HNB{1'b0}}, lo_strb};
      rd_be_o  = a1_o ? {{HNB{1'b1}}, {HNB{1'b0}}} : {{HNB{1'b0}}, {HNB{1'b1}}};
      wdata_o  = {data_i[HALF-1:0], data_i[HALF-1:0]};
    end
  end

  always_comb begin
    pin_rdata_o = rdata_q_i;
    if (!bus32_q_i && a1_q_i) pin_rdata_o[HALF-1:0] = rdata_q_i[DATA_W-1:HALF];
  end
endmodule

// File: rtl/hbus_seq.sv
module hbus_seq
  import hbus_pkg::*;
#(
  parameter int unsigned WADDR_W = 22,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_AW  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_s_i,
  input  logic                rd_s_i,
  input  logic                wr_s_i,
  input  logic                mem_i,
  input  logic [WADDR_W-1:0]  addr_i,
  input  logic [DATA_W/8-1:0] wr_be_i,
  input  logic [DATA_W/8-1:0] rd_be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                a1_i,
  input  logic                bus32_i,
  input  logic                ack_i,
  input  logic [DATA_W-1:0]   ack_rdata_i,
  output logic                req_o,
  output logic                req_we_o,
  output logic                req_mem_o,
  output logic [WADDR_W-1:0]  req_addr_o,
  output logic [DATA_W/8-1:0] req_be_o,
  output logic [DATA_W-1:0]   req_wdata_o,
  output logic [DATA_W-1:0]   rdata_q_o,
  output logic                a1_q_o,
  output logic                bus32_q_o,
  output logic                done_o
);
  localparam int unsigned NB     = DATA_W / 8;
  localparam int unsigned HNB    = NB / 2;
  localparam int unsigned REG_WA = REG_AW - 2;

  seq_state_t state_q, state_d;
  logic       start, capture_en, rdata_en;
  logic [WADDR_W-1:0] addr_eff;

  assign start = cs_s_i && (rd_s_i || wr_s_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (start) state_d = SEQ_REQ;
      SEQ_REQ:  if (ack_i) state_d = SEQ_DONE;
      SEQ_DONE: if (!rd_s_i && !wr_s_i) state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign capture_en = (state_q == SEQ_IDLE) && start;
  assign rdata_en   = (state_q == SEQ_REQ) && ack_i && !req_we_o;

  always_comb begin
    addr_eff = addr_i;
    if (!mem_i) addr_eff = {{(WADDR_W-REG_WA){1'b0}}, addr_i[REG_WA-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_we_o    <= 1'b0;
      req_mem_o   <= 1'b0;
      req_addr_o  <= '0;
      req_be_o    <= '0;
      req_wdata_o <= '0;
      a1_q_o      <= 1'b0;
      bus32_q_o   <= 1'b1;
    end else if (capture_en) begin
      req_we_o    <= wr_s_i;
      req_mem_o   <= mem_i;
      req_addr_o  <= addr_eff;
      req_be_o    <= wr_s_i ? wr_be_i : rd_be_i;
      req_wdata_o <= wdata_i;
      a1_q_o      <= a1_i;
      bus32_q_o   <= bus32_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q_o <= '0;
    else if (rdata_en) rdata_q_o <= ack_rdata_i;
  end

  assign req_o  = (state_q == SEQ_REQ);
  assign done_o = (state_q == SEQ_DONE);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ack_i |=> req_o);
  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(ack_i));
  // R3
  reg_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !req_mem_o |-> req_addr_o[WADDR_W-1:REG_WA] == '0);
  // R2
  half_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !bus32_q_o |-> (req_be_o[NB-1:HNB] == '0) || (req_be_o[HNB-1:0] == '0));
  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && $past(done_o) |-> $stable(rdata_q_o));
endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
  import hbus_pkg::*;
#(
  parameter int unsigned ADDR_W      = HB_ADDR_W,
  parameter int unsigned DATA_W      = HB_DATA_W,
  parameter int unsigned REG_AW      = HB_REG_AW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus32_i,
  input  logic                   cs_reg_n_i,
  input  logic                   cs_mem_n_i,
  input  logic                   rd_n_i,
  input  logic [DATA_W/8-1:0]    wr_n_i,
  input  logic [ADDR_W-1:2]      addr_i,
  input  logic [DATA_W-1:0]      data_i,
  output logic [DATA_W-1:0]      data_o,
  output logic [1:0]             data_oe_o,
  output logic                   wait_n_o,
  output logic                   wait_oe_o,
  output logic                   ready_o,
  output logic                   ready_oe_o,
  output logic                   req_o,
  output logic                   req_we_o,
  output logic                   req_mem_o,
  output logic [ADDR_W-1:2]      req_addr_o,
  output logic [DATA_W/8-1:0]    req_be_o,
  output logic [DATA_W-1:0]      req_wdata_o,
  input  logic                   ack_i,
  input  logic [DATA_W-1:0]      ack_rdata_i
);
  localparam int unsigned NB      = DATA_W / 8;
  localparam int unsigned WADDR_W = ADDR_W - 2;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic cs_any, rd_act, wr_act, strobe_raw, a1;
  logic [NB-1:0]     wr_be, rd_be;
  logic [DATA_W-1:0] wdata_m, rdata_q, pin_rdata;
  logic a1_q, bus32_q, done;
  logic [2:0] sync_d, sync_q;

  assign cs_any     = !cs_reg_n_i || !cs_mem_n_i;
  assign rd_act     = !rd_n_i;
  assign strobe_raw = rd_act || wr_act;

  hbus_lane_map #(.DATA_W(DATA_W)) i_lane (
    .bus32_i     (bus32_i),
    .wr_n_i      (wr_n_i),
    .data_i      (data_i),
    .bus32_q_i   (bus32_q),
    .a1_q_i      (a1_q),
    .rdata_q_i   (rdata_q),
    .wr_act_o    (wr_act),
    .a1_o        (a1),
    .wr_be_o     (wr_be),
    .rd_be_o     (rd_be),
    .wdata_o     (wdata_m),
    .pin_rdata_o (pin_rdata)
  );

  assign sync_d = {cs_any, rd_act, wr_act};

  hbus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (sync_d),
    .q_o   (sync_q)
  );

  hbus_seq #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) i_seq (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .cs_s_i      (sync_q[2]),
    .rd_s_i      (sync_q[1]),
    .wr_s_i      (sync_q[0]),
    .mem_i       (cs_reg_n_i),
    .addr_i      (addr_i),
    .wr_be_i     (wr_be),
    .rd_be_i     (rd_be),
    .wdata_i     (wdata_m),
    .a1_i        (a1),
    .bus32_i     (bus32_i),
    .ack_i       (ack_i),
    .ack_rdata_i (ack_rdata_i),
    .req_o       (req_o),
    .req_we_o    (req_we_o),
    .req_mem_o   (req_mem_o),
    .req_addr_o  (req_addr_o),
    .req_be_o    (req_be_o),
    .req_wdata_o (req_wdata_o),
    .rdata_q_o   (rdata_q),
    .a1_q_o      (a1_q),
    .bus32_q_o   (bus32_q),
    .done_o      (done)
  );

  assign data_o       = pin_rdata;
  assign data_oe_o[0] = cs_any && rd_act;
  assign data_oe_o[1] = cs_any && rd_act && bus32_i;
  assign wait_oe_o    = cs_any;
  assign ready_oe_o   = cs_any;
  assign wait_n_o     = !strobe_raw || done;
  assign ready_o      = !strobe_raw || done;

  // R6
  ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    req_o && ack_i |=> ready_o || !strobe_raw);
  // R9
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(req_o) |-> $past(strobe_raw, 2));
endmodule

// File: tb/test_hbus_slave.sv
`timescale 1ns/1ps
module test_hbus_slave;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus32_i, cs_reg_n_i, cs_mem_n_i, rd_n_i;
  logic [3:0]  wr_n_i;
  logic [23:2] addr_i;
  logic [31:0] data_i, data_o;
  logic [1:0]  data_oe_o;
  logic        wait_n_o, wait_oe_o, ready_o, ready_oe_o;
  logic        req_o, req_we_o, req_mem_o;
  logic [23:2] req_addr_o;
  logic [3:0]  req_be_o;
  logic [31:0] req_wdata_o;
  logic        ack_i;
  logic [31:0] ack_rdata_i;

  always #2 clk = ~clk;

  hbus_slave i_hbus_slave (
    .clk(clk), .rst_n(rst_n), .bus32_i(bus32_i), .cs_reg_n_i(cs_reg_n_i),
    .cs_mem_n_i(cs_mem_n_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .addr_i(addr_i),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .wait_n_o(wait_n_o),
    .wait_oe_o(wait_oe_o), .ready_o(ready_o), .ready_oe_o(ready_oe_o),
    .req_o(req_o), .req_we_o(req_we_o), .req_mem_o(req_mem_o),
    .req_addr_o(req_addr_o), .req_be_o(req_be_o), .req_wdata_o(req_wdata_o),
    .ack_i(ack_i), .ack_rdata_i(ack_rdata_i)
  );

  typedef struct packed {
    logic        we;
    logic        mem;
    logic [21:0] wa;
    logic [3:0]  be;
    logic [31:0] wd;
  } exp_t;

  exp_t exp_q[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   lat     = 2;
  int   req_cnt = 0;
  logic req_prev = 1'b0;
  bit   finished = 1'b0;

  function automatic logic [31:0] rdf(input logic [21:0] wa);
    return {8'h5A, wa, 2'b11};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // responder and scoreboard monitor
  initial begin
    int cnt;
    exp_t e;
    cnt = 0;
    ack_i = 1'b0;
    ack_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (req_o && !req_prev) req_cnt++;
      req_prev = req_o;
      if (ack_i) ack_i = 1'b0;
      else if (req_o) begin
        if (cnt >= lat) begin
          ack_i = 1'b1;
          ack_rdata_i = rdf(req_addr_o);
          cnt = 0;
          if (exp_q.size() == 0) check(1'b0, "R7 unexpected request", 64'(req_addr_o), 0);
          else begin
            e = exp_q.pop_front();
            check(req_we_o == e.we, "R1 request direction", 64'(req_we_o), 64'(e.we));
            check(req_mem_o == e.mem, "R3 request space", 64'(req_mem_o), 64'(e.mem));
            check(req_addr_o == e.wa, "R3 request address", 64'(req_addr_o), 64'(e.wa));
            check(req_be_o == e.be, "R2 R8 byte enables", 64'(req_be_o), 64'(e.be));
            if (e.we) check(req_wdata_o == e.wd, "R1 R2 write data", req_wdata_o, e.wd);
          end
        end else cnt++;
      end
    end
  end

  // one host access; hold = extra cycles with strobe held after ready
  task automatic access(input bit b32, input bit mem, input bit both, input logic [23:0] a,
                        input bit we, input logic [3:0] wrn, input logic [31:0] wd,
                        input int latv, input int hold);
    exp_t e;
    logic [31:0] exp_rd, first_rd;
    int n0;
    bit got;
    lat = latv;
    e.we  = we;
    e.mem = mem && !both;
    e.wa  = e.mem ? a[23:2] : {16'b0, a[7:2]};
    if (we) e.be = b32 ? ~wrn : (a[1] ? {~wrn[1:0], 2'b00} : {2'b00, ~wrn[1:0]});
    else    e.be = b32 ? 4'b1111 : (a[1] ? 4'b1100 : 4'b0011);
    e.wd  = b32 ? wd : {wd[15:0], wd[15:0]};
    exp_q.push_back(e);
    exp_rd = rdf(e.wa);
    if (!b32 && a[1]) exp_rd[15:0] = exp_rd[31:16];
    n0 = req_cnt;
    @(posedge clk); #1;
    bus32_i = b32; addr_i = a[23:2]; data_i = wd;
    cs_reg_n_i = !(both || !mem);
    cs_mem_n_i = !mem;
    @(posedge clk); #1;
    if (we) wr_n_i = b32 ? wrn : {a[1], 1'b1, wrn[1:0]};
    else begin
      rd_n_i = 1'b0;
      if (!b32) wr_n_i = {a[1], 3'b111};
    end
    @(negedge clk);
    check(wait_n_o == 1'b0 && ready_o == 1'b0 && wait_oe_o, "R6 pending wait/ready", {wait_oe_o, wait_n_o, ready_o}, 3'b100);
    check(req_o == 1'b0, "R9 no request after first edge", 64'(req_o), 0);
    @(negedge clk);
    check(req_o == 1'b0, "R9 no request after second edge", 64'(req_o), 0);
    got = 1'b0;
    for (int i = 0; i < 60 && !got; i++) begin
      @(negedge clk);
      if (ready_o) got = 1'b1;
    end
    check(got && wait_n_o, "R6 completion", {ready_o, wait_n_o}, 2'b11);
    if (!we) begin
      check(data_oe_o == (b32 ? 2'b11 : 2'b01), "R4 data enable while reading", 64'(data_oe_o), b32 ? 3 : 1);
      if (b32) check(data_o == exp_rd, "R4 read data", data_o, exp_rd);
      else     check(data_o[15:0] == exp_rd[15:0], "R2 R4 half read data", 64'(data_o[15:0]), 64'(exp_rd[15:0]));
    end
    first_rd = data_o;
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      check(req_cnt == n0 + 1, "R7 single request per strobe", 64'(req_cnt - n0), 1);
      check(ready_o && wait_n_o, "R6 stays complete", {ready_o, wait_n_o}, 2'b11);
      if (!we) check(data_o == first_rd, "R8 read data held", data_o, first_rd);
    end
    @(posedge clk); #1;
    rd_n_i = 1'b1; wr_n_i = 4'b1111;
    @(negedge clk);
    check(data_oe_o == 2'b00 && wait_n_o && ready_o, "R4 R5 strobe released", {data_oe_o, wait_n_o, ready_o}, 4'b0011);
    repeat (4) @(posedge clk); #1;
    cs_reg_n_i = 1'b1; cs_mem_n_i = 1'b1;
    @(negedge clk);
    check(!wait_oe_o && !ready_oe_o, "R5 deselected high-Z", {wait_oe_o, ready_oe_o}, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    bus32_i = 1'b1; cs_reg_n_i = 1'b1; cs_mem_n_i = 1'b1; rd_n_i = 1'b1;
    wr_n_i = 4'b1111; addr_i = '0; data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!wait_oe_o && !ready_oe_o && !req_o && data_oe_o == 2'b00, "R5 reset state",
          {wait_oe_o, ready_oe_o, req_o, data_oe_o}, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    cs_mem_n_i = 1'b0;
    repeat (3) @(negedge clk);
    check(wait_oe_o && ready_oe_o && wait_n_o && ready_o && data_oe_o == 2'b00, "R5 selected idle high",
          {wait_oe_o, ready_oe_o, wait_n_o, ready_o, data_oe_o}, 6'b111100);
    cs_mem_n_i = 1'b1;
    // 32-bit writes: full and partial lanes, both spaces
    access(1, 1, 0, 24'hABCDE4, 1, 4'b0000, 32'h11223344, 2, 0);
    access(1, 1, 0, 24'h123458, 1, 4'b1010, 32'hCAFEF00D, 5, 0);
    access(1, 0, 0, 24'hFFFF3C, 1, 4'b0111, 32'hDEADBEEF, 1, 0);
    // 32-bit reads, register space upper bits dropped, memory full address
    access(1, 0, 0, 24'h8765F0, 0, 4'b1111, 32'h0, 3, 0);
    access(1, 1, 0, 24'h8765F0, 0, 4'b1111, 32'h0, 7, 6);
    // both selects: register space wins
    access(1, 1, 1, 24'h55AA14, 0, 4'b1111, 32'h0, 2, 0);
    // 16-bit mode: both halves, read and write
    access(0, 1, 0, 24'h000102, 0, 4'b1111, 32'h0, 2, 0);
    access(0, 1, 0, 24'h000100, 0, 4'b1111, 32'h0, 4, 8);
    access(0, 1, 0, 24'h0A0002, 1, 4'b1100, 32'hFFFF9876, 2, 0);
    access(0, 0, 0, 24'h0A0020, 1, 4'b1110, 32'hFFFF4321, 3, 5);
    // 16-bit: byte-2 strobe ignored, A1 pin alone makes no request
    begin
      int n0;
      n0 = req_cnt;
      @(posedge clk); #1;
      bus32_i = 1'b0; cs_mem_n_i = 1'b0; wr_n_i = 4'b1011;
      repeat (8) @(negedge clk);
      check(req_cnt == n0 && wait_n_o && ready_o, "R2 byte-2 strobe ignored",
            {32'(req_cnt - n0), wait_n_o, ready_o}, 2'b11);
      @(posedge clk); #1;
      wr_n_i = 4'b1111; cs_mem_n_i = 1'b1; bus32_i = 1'b1;
      repeat (4) @(posedge clk);
    end
    check(exp_q.size() == 0, "R7 all requests seen", 64'(exp_q.size()), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule